// File: doc/BRIEF.md
# Text Command Bus Master with Serial Rate Detection

This block sits between a byte-level serial receiver/transmitter pair and a single-master memory-mapped bus. A host terminal types short text commands; the block decodes them into one bus read or one bus write each and answers with text. A write is the letter `w`, four hexadecimal address digits and four hexadecimal data digits (for example `w 0000 1234`). A read is the letter `r` and four address digits, and the block replies with the word it read.

Before any command is decoded, the block watches the raw serial line and times the start bit of the first character the host sends, a carriage return. In normal use the link runs at 9600 baud with no flow control. The measured bit period, and half of it for mid-bit sampling, are handed to the external serial shift logic. Once the rate is known the block prints a `>` prompt and starts decoding.

Bytes are taken one at a time from the receiver. There is no input buffer: characters that arrive while a bus cycle or a reply is in progress are discarded. Replies are offered to the transmitter one byte at a time with a valid/ready handshake.

Top module: `acm_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `wb_cyc`, `wb_stb`, `tx_valid` and `baud_locked` are 0.
- R2: After the serial line has been seen high, the first low pulse of at least MIN_LOW clock cycles sets `bit_period` to its length in cycles, `half_period` to that value halved (rounded down) and `baud_locked` to 1. Shorter pulses before lock are ignored, and line activity after lock changes none of the three outputs.
- R3: Received bytes are ignored until `baud_locked` is 1; after lock the block sends exactly one `>` (0x3E) prompt.
- R4: `w` (0x77), 4 hex address digits, then 4 hex data digits produce one bus cycle with `wb_we`=1, `wb_adr` equal to the address and `wb_dat_o` equal to the data (first digit most significant); the reply is `>` alone.
- R5: `r` (0x72) followed by 4 hex address digits produces one bus cycle with `wb_we`=0; the reply is the read word as 4 uppercase hex characters (most significant first, digits 0x30-0x39 and 0x41-0x46), then 0x0D, 0x0A and `>`.
- R6: Spaces (0x20), carriage returns (0x0D) and line feeds (0x0A) before the opcode are skipped, spaces before the first digit of each field are skipped, and hex digits a-f are accepted in either case.
- R7: Any other character in place of an opcode, or any non-hex character inside a field (including a space after the field's first digit), abandons the command without a bus cycle and sends `>`.
- R8: `wb_cyc` and `wb_stb` rise and fall together; address, data and `wb_we` are held until `wb_ack`, and both strobes are low in the cycle after the acknowledge.
- R9: Once `tx_valid` is 1, it and `tx_byte` stay unchanged until a cycle with `tx_ready` high.
- R10: Bytes arriving during a bus cycle (including its acknowledge cycle) or while a reply is being sent are discarded and do not change the reply or start another command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_line | input | 1 | Raw serial receive line, idle high, used for rate detection |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is new |
| tx_byte | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Transmitter accepts `tx_byte` this cycle |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | 1 for write, 0 for read |
| wb_adr | output | AW | Bus address |
| wb_dat_o | output | DW | Write data |
| wb_dat_i | input | DW | Read data from the slave |
| wb_ack | input | 1 | Slave acknowledge |
| bit_period | output | CW | Measured bit length in clock cycles |
| half_period | output | CW | Half the bit length, for mid-bit sampling |
| baud_locked | output | 1 | Bit rate has been measured |

## Verification
The two functions that can meet in one cycle are the completion of a bus cycle (the slave acknowledge and the hand-off to the reply) and the arrival of a new received byte. The bench provokes this by waiting for the acknowledge to rise and presenting a command letter in that very cycle and the next, then injecting another byte while a stalled transmitter holds the reply. It judges the outcome at the ports: the reply must be exactly the read word with its line ending and one prompt, only one bus cycle may have occurred, and a following command must decode normally.

// File: rtl/acm_pkg.sv
package acm_pkg;

  localparam logic [7:0] CH_SPACE  = 8'h20;
  localparam logic [7:0] CH_CR     = 8'h0D;
  localparam logic [7:0] CH_LF     = 8'h0A;
  localparam logic [7:0] CH_PROMPT = 8'h3E;
  localparam logic [7:0] CH_READ   = 8'h72;
  localparam logic [7:0] CH_WRITE  = 8'h77;

  typedef enum logic [2:0] {
    P_BOOT, P_IDLE, P_ADDR, P_DATA, P_BUS, P_SEND
  } parse_st_t;

  typedef enum logic [1:0] {
    L_ARM, L_WAIT, L_LOW, L_DONE
  } lock_st_t;

  // ASCII character is a hexadecimal digit (either case)
  function automatic logic is_hex(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) ||
           ((c >= 8'h41) && (c <= 8'h46)) ||
           ((c >= 8'h61) && (c <= 8'h66));
  endfunction

  // value of a hex character; only meaningful when is_hex holds
  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39)      t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else                 t = c - 8'h57;
    return t[3:0];
  endfunction

  // uppercase hex character for a nibble
  function automatic logic [7:0] hex_chr(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/acm_baud_lock.sv
module acm_baud_lock
  import acm_pkg::*;
#(
  parameter int CW      = 16,
  parameter int MIN_LOW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd_line,
  output logic [CW-1:0] bit_period,
  output logic [CW-1:0] half_period,
  output logic          locked
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] LOW_MIN = CW'(MIN_LOW);

  logic [1:0]    sync_q;
  logic          line;
  lock_st_t      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd_line};
  end

  assign line = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= L_ARM;
      cnt         <= '0;
      bit_period  <= '0;
      half_period <= '0;
      locked      <= 1'b0;
    end else begin
      unique case (st)
        L_ARM:  if (line) st <= L_WAIT;
        L_WAIT: if (!line) begin
          cnt <= CW'(1);
          st  <= L_LOW;
        end
        L_LOW: begin
          if (!line) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end else if (cnt >= LOW_MIN) begin
            bit_period  <= cnt;
            half_period <= cnt >> 1;
            locked      <= 1'b1;
            st          <= L_DONE;
          end else begin
            st <= L_WAIT;
          end
        end
        default: st <= L_DONE;
      endcase
    end
  end

  // R2: lock and measured values never change once taken
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(bit_period) && $stable(half_period)));

  // R2: a locked period is never shorter than the glitch limit
  a_r2_no_short_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (bit_period >= LOW_MIN));

endmodule

// File: rtl/acm_bus_port.sv
module acm_bus_port
  import acm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we_in,
  input  logic [AW-1:0] adr_in,
  input  logic [DW-1:0] dat_in,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cyc   <= 1'b0;
      wb_stb   <= 1'b0;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_dat_o <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wb_cyc) begin
        if (wb_ack) begin
          wb_cyc <= 1'b0;
          wb_stb <= 1'b0;
          done   <= 1'b1;
          if (!wb_we) rdata <= wb_dat_i;
        end
      end else if (start) begin
        wb_cyc   <= 1'b1;
        wb_stb   <= 1'b1;
        wb_we    <= we_in;
        wb_adr   <= adr_in;
        wb_dat_o <= dat_in;
      end
    end
  end

  // R8: request held steady until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_adr) &&
                             $stable(wb_we) && $stable(wb_dat_o)));

  // R8: cycle ends right after the acknowledge
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_ack) |=> (!wb_cyc && !wb_stb && done));

  // R10: the parser never requests a new cycle while one is open
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    start |-> !wb_cyc);

endmodule

// File: rtl/acm_cmd_fsm.sv
module acm_cmd_fsm
  import acm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          bus_start,
  output logic          bus_we,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_wdat,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata
);

  localparam int ANIB     = AW / 4;
  localparam int DNIB     = DW / 4;
  localparam int SEQ_LAST = DNIB + 2;
  localparam int SW       = $clog2(SEQ_LAST + 1);
  localparam logic [3:0]    ADDR_END = 4'(ANIB - 1);
  localparam logic [3:0]    DATA_END = 4'(DNIB - 1);
  localparam logic [SW-1:0] SEQ_CR   = SW'(DNIB);
  localparam logic [SW-1:0] SEQ_LF   = SW'(DNIB + 1);
  localparam logic [SW-1:0] SEQ_END  = SW'(SEQ_LAST);

  parse_st_t     st;
  logic          is_rd;
  logic [3:0]    dcnt;
  logic [AW-1:0] adr_sh;
  logic [DW-1:0] dat_sh;
  logic [SW-1:0] seq;

  logic       hex_ok;
  logic [3:0] nib_in;
  logic       blank;
  logic       line_end;
  logic [3:0] nib_out;
  logic [7:0] next_chr;

  always_comb begin
    hex_ok   = is_hex(rx_byte);
    nib_in   = hex_val(rx_byte);
    blank    = (rx_byte == CH_SPACE);
    line_end = (rx_byte == CH_CR) || (rx_byte == CH_LF);
  end

  // pick the nibble of the read word for reply position seq
  always_comb begin
    nib_out = '0;
    for (int i = 0; i < DNIB; i++) begin
      if (seq == SW'(i)) nib_out = bus_rdata[4*(DNIB-1-i) +: 4];
    end
  end

  always_comb begin
    if (seq < SEQ_CR)       next_chr = hex_chr(nib_out);
    else if (seq == SEQ_CR) next_chr = CH_CR;
    else if (seq == SEQ_LF) next_chr = CH_LF;
    else                    next_chr = CH_PROMPT;
  end

  assign bus_we   = !is_rd;
  assign bus_adr  = adr_sh;
  assign bus_wdat = dat_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_BOOT;
      is_rd     <= 1'b0;
      dcnt      <= '0;
      adr_sh    <= '0;
      dat_sh    <= '0;
      seq       <= SEQ_END;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      bus_start <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      unique case (st)
        P_BOOT: if (locked) begin
          seq <= SEQ_END;
          st  <= P_SEND;
        end
        P_IDLE: if (rx_valid) begin
          if ((rx_byte == CH_READ) || (rx_byte == CH_WRITE)) begin
            is_rd <= (rx_byte == CH_READ);
            dcnt  <= '0;
            st    <= P_ADDR;
          end else if (!(blank || line_end)) begin
            seq <= SEQ_END;
            st  <= P_SEND;
          end
        end
        P_ADDR: if (rx_valid) begin
          if (hex_ok) begin
            adr_sh <= (adr_sh << 4) | AW'(nib_in);
            if (dcnt == ADDR_END) begin
              dcnt <= '0;
              if (is_rd) begin
                bus_start <= 1'b1;
                st        <= P_BUS;
              end else begin
                st <= P_DATA;
              end
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end else if (!(blank && (dcnt == '0))) begin
            seq <= SEQ_END;
            st  <= P_SEND;
          end
        end
        P_DATA: if (rx_valid) begin
          if (hex_ok) begin
            dat_sh <= (dat_sh << 4) | DW'(nib_in);
            if (dcnt == DATA_END) begin
              dcnt      <= '0;
              bus_start <= 1'b1;
              st        <= P_BUS;
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end else if (!(blank && (dcnt == '0))) begin
            seq <= SEQ_END;
            st  <= P_SEND;
          end
        end
        P_BUS: if (bus_done) begin
          seq <= is_rd ? '0 : SEQ_END;
          st  <= P_SEND;
        end
        P_SEND: begin
          if (!tx_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= next_chr;
          end else if (tx_ready) begin
            tx_valid <= 1'b0;
            if (seq == SEQ_END) st <= P_IDLE;
            else                seq <= seq + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // R3: nothing is transmitted before the rate is known
  a_r3_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !tx_valid);

  // R9: offered byte held until accepted
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R10: a bus completion is only ever seen while waiting for it
  a_r10_done_in_bus: assert property (@(posedge clk) disable iff (rst)
    bus_done |-> (st == P_BUS));

  // R7: a cycle is only requested on entry to the bus wait
  a_r7_start_only_to_bus: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> (st == P_BUS));

endmodule

// File: rtl/acm_master.sv
module acm_master
  import acm_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int MIN_LOW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd_line,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack,
  output logic [CW-1:0] bit_period,
  output logic [CW-1:0] half_period,
  output logic          baud_locked
);

  logic          bus_start;
  logic          bus_we;
  logic [AW-1:0] bus_adr;
  logic [DW-1:0] bus_wdat;
  logic          bus_done;
  logic [DW-1:0] bus_rdata;

  acm_baud_lock #(.CW(CW), .MIN_LOW(MIN_LOW)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .rxd_line    (rxd_line),
    .bit_period  (bit_period),
    .half_period (half_period),
    .locked      (baud_locked)
  );

  acm_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .locked    (baud_locked),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .tx_byte   (tx_byte),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .bus_start (bus_start),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .bus_wdat  (bus_wdat),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata)
  );

  acm_bus_port #(.AW(AW), .DW(DW)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .start    (bus_start),
    .we_in    (bus_we),
    .adr_in   (bus_adr),
    .dat_in   (bus_wdat),
    .done     (bus_done),
    .rdata    (bus_rdata),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_dat_i (wb_dat_i),
    .wb_ack   (wb_ack)
  );

  // R3: no bus traffic before the rate is known
  a_r3_no_bus_unlocked: assert property (@(posedge clk) disable iff (rst)
    !baud_locked |-> !wb_cyc);

  // R8: the two strobes always move together
  a_r8_cyc_stb_pair: assert property (@(posedge clk) disable iff (rst)
    wb_cyc == wb_stb);

endmodule

// File: tb/tb_acm_master.sv
module tb_acm_master;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rxd_line = 1'b1;
  logic [7:0]    rx_byte = 8'h00;
  logic          rx_valid = 1'b0;
  logic [7:0]    tx_byte;
  logic          tx_valid;
  logic          tx_ready;
  logic          wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_o;
  logic [DW-1:0] wb_dat_i;
  logic          wb_ack;
  logic [CW-1:0] bit_period, half_period;
  logic          baud_locked;

  always #4 clk = ~clk;

  acm_master #(.AW(AW), .DW(DW), .CW(CW), .MIN_LOW(4)) dut (
    .clk(clk), .rst(rst), .rxd_line(rxd_line),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack),
    .bit_period(bit_period), .half_period(half_period), .baud_locked(baud_locked)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- bus slave model ----------------
  logic [15:0] mem [0:15];
  int          ack_delay = 0;
  int          bus_cnt = 0;
  logic [15:0] last_adr = '0;
  logic [15:0] last_dat = '0;
  logic        last_we = 1'b0;
  int          proto_err = 0;

  initial begin
    int wc = 0;
    wb_ack   = 1'b0;
    wb_dat_i = '0;
    forever begin
      @(negedge clk);
      if (wb_cyc !== wb_stb) proto_err++;
      if (wb_ack) begin
        wb_ack = 1'b0;
      end else if (wb_cyc === 1'b1) begin
        if (wc >= ack_delay) begin
          wc       = 0;
          wb_ack   = 1'b1;
          bus_cnt++;
          last_adr = wb_adr;
          last_we  = wb_we;
          last_dat = wb_dat_o;
          if (wb_we) mem[wb_adr[3:0]] = wb_dat_o;
          else       wb_dat_i = mem[wb_adr[3:0]];
        end else begin
          wc++;
        end
      end
    end
  end

  // ---------------- transmit sink ----------------
  logic [7:0] txlog[$];
  int         tx_stall = 0;
  int         hold_err = 0;

  initial begin
    int         ph = 0;
    logic       pv = 1'b0;
    logic       prdy = 1'b0;
    logic [7:0] pb = 8'h00;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (pv && !prdy && ((tx_valid !== 1'b1) || (tx_byte !== pb))) hold_err++;
      ph++;
      prdy     = (tx_stall == 0) || (ph % 3 == 0);
      tx_ready = prdy;
      pv       = (tx_valid === 1'b1);
      pb       = tx_byte;
      if ((tx_valid === 1'b1) && prdy) txlog.push_back(tx_byte);
    end
  end

  // ---------------- helpers ----------------
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic wait_prompt();
    int n = 0;
    while (!((txlog.size() > 0) && (txlog[txlog.size()-1] == 8'h3E)) && (n < 3000)) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_log(input string exp, input string req);
    string got = "";
    bit    ok;
    foreach (txlog[i]) got = $sformatf("%s%c", got, txlog[i]);
    ok = (got == exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s reply: actual \"%s\" expected \"%s\"", req, got, exp);
    end
  endtask

  task automatic line_low(input int n);
    @(negedge clk);
    rxd_line = 1'b0;
    repeat (n) @(negedge clk);
    rxd_line = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(wb_cyc == 0 && wb_stb == 0, "R1", "bus idle in reset", {wb_cyc, wb_stb}, 0);
    chk(tx_valid == 0, "R1", "tx idle in reset", tx_valid, 0);
    chk(baud_locked == 0, "R1", "unlocked in reset", baud_locked, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wb_cyc == 0 && tx_valid == 0 && baud_locked == 0, "R1", "idle after reset",
        {wb_cyc, tx_valid, baud_locked}, 0);
  endtask

  task automatic t_prelock();
    send_str("r 0001");
    repeat (10) @(negedge clk);
    chk(bus_cnt == 0, "R3", "no bus cycle before lock", bus_cnt, 0);
    chk(txlog.size() == 0, "R3", "no output before lock", txlog.size(), 0);
  endtask

  task automatic t_glitch();
    line_low(2);
    chk(baud_locked == 0, "R2", "short pulse ignored", baud_locked, 0);
  endtask

  task automatic t_baud();
    txlog.delete();
    line_low(37);
    chk(baud_locked == 1, "R2", "locked", baud_locked, 1);
    chk(bit_period == 37, "R2", "bit period", bit_period, 37);
    chk(half_period == 18, "R2", "half period", half_period, 18);
    wait_prompt();
    expect_log(">", "R3");
    line_low(6);
    chk(bit_period == 37 && half_period == 18, "R2", "period kept after lock",
        bit_period, 37);
    chk(txlog.size() == 1, "R3", "single prompt", txlog.size(), 1);
  endtask

  task automatic t_write();
    int b0 = bus_cnt;
    txlog.delete();
    send_str("w 0003 BEEF");
    wait_prompt();
    chk(bus_cnt == b0 + 1, "R4", "one write cycle", bus_cnt, b0 + 1);
    chk(last_we == 1, "R4", "we set", last_we, 1);
    chk(last_adr == 16'h0003, "R4", "write address", last_adr, 16'h0003);
    chk(last_dat == 16'hBEEF, "R4", "write data", last_dat, 16'hBEEF);
    expect_log(">", "R4");
  endtask

  task automatic t_write_mixed();
    txlog.delete();
    send_str("\r\n w0005 12ab");
    wait_prompt();
    chk(last_adr == 16'h0005 && last_we == 1, "R6", "address no space", last_adr, 16'h0005);
    chk(last_dat == 16'h12AB, "R6", "lowercase hex data", last_dat, 16'h12AB);
    expect_log(">", "R6");
  endtask

  task automatic t_read_stalled();
    int b0 = bus_cnt;
    txlog.delete();
    tx_stall = 1;
    send_str("r 0003");
    wait_prompt();
    tx_stall = 0;
    chk(bus_cnt == b0 + 1 && last_we == 0, "R5", "one read cycle", bus_cnt, b0 + 1);
    chk(last_adr == 16'h0003, "R5", "read address", last_adr, 16'h0003);
    expect_log("BEEF\r\n>", "R5");
  endtask

  task automatic t_read_slow_ack();
    txlog.delete();
    ack_delay = 3;
    send_str("  r   0005");
    wait_prompt();
    ack_delay = 0;
    expect_log("12AB\r\n>", "R8");
  endtask

  task automatic t_bad_opcode();
    int b0 = bus_cnt;
    txlog.delete();
    send_str("x");
    wait_prompt();
    chk(bus_cnt == b0, "R7", "no cycle on bad opcode", bus_cnt, b0);
    expect_log(">", "R7");
  endtask

  task automatic t_bad_digit();
    int b0 = bus_cnt;
    txlog.delete();
    send_str("w 00g");
    wait_prompt();
    chk(bus_cnt == b0, "R7", "no cycle on bad digit", bus_cnt, b0);
    expect_log(">", "R7");
    txlog.delete();
    send_str("r 00 ");
    wait_prompt();
    chk(bus_cnt == b0, "R7", "no cycle on inner space", bus_cnt, b0);
    expect_log(">", "R7");
  endtask

  task automatic t_collide();
    int b0 = bus_cnt;
    txlog.delete();
    ack_delay = 4;
    tx_stall  = 1;
    send_str("r 0003");
    @(posedge wb_ack);
    rx_byte  = 8'h77;
    rx_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rx_byte  = 8'h78;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    wait_prompt();
    tx_stall  = 0;
    ack_delay = 0;
    expect_log("BEEF\r\n>", "R10");
    repeat (20) @(negedge clk);
    chk(bus_cnt == b0 + 1, "R10", "no extra cycle", bus_cnt, b0 + 1);
    chk(txlog.size() == 7, "R10", "no extra output", txlog.size(), 7);
    txlog.delete();
    send_str("r 0005");
    wait_prompt();
    expect_log("12AB\r\n>", "R10");
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    t_prelock();
    t_glitch();
    t_baud();
    t_write();
    t_write_mixed();
    t_read_stalled();
    t_read_slow_ack();
    t_bad_opcode();
    t_bad_digit();
    t_collide();
    chk(hold_err == 0, "R9", "tx byte held while stalled", hold_err, 0);
    chk(proto_err == 0, "R8", "cyc and stb paired", proto_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule